// File: doc/BRIEF.md
# Pixel-to-Bus Cycle Serializer

This block sits between a pixel stream and the bus cycle generator of a parallel display interface. Each incoming pixel is split into one or more data write requests, sized to the number of data lines the panel bus uses. Pixels wider than the bus go out most significant part first. When the pixel is one and a half bus widths, two pixels are packed into three bus words. The block also counts the pixels of one update and raises a one-cycle completion pulse after the last word of the last pixel has been accepted.

Software sets the pixel type, the bus width and the pixel count (width times height), then pulses `start`. The block derives the cycle format from the ratio of pixel bits to bus lines. It refuses any pairing whose ratio is not 1, 2, 3 or 1.5. While a frame is running, `busy` plays the role of the self-clearing enable bit.

Top module: `pix_bus_serializer`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `pix_ready` and `frame_done` are low.
- R2: Pixel type codes are 0=12, 1=16, 2=18 and 3=24 bits. Bus codes are 0=8, 1=9, 2=12 and 3=16 lines. `cfg_bad` is high exactly when bits/lines is not 1, 2, 3 or 1.5. A `start` given with such a pairing leaves `busy` low.
- R3: When bits equal lines, each pixel produces one word holding the pixel's bits.
- R4: When bits are twice the lines, each pixel produces two words: the upper half of the pixel first, then the lower half.
- R5: When bits are three times the lines, each pixel produces three words, most significant first (for 24 bits on 8 lines: bits 23:16, then 15:8, then 7:0).
- R6: When bits are 1.5 times the lines, each pair of pixels A, B produces three words, in this order:
  - the upper L bits of A;
  - the lower L/2 bits of A above the upper L/2 bits of B;
  - the lower L bits of B.
- R7: In the 1.5 ratio with an odd count, the final lone pixel produces only the first two words, with zeros in place of B.
- R8: Pixel input bits above the pixel type width are ignored. Word bits at and above the bus line count are zero.
- R9: A frame consumes exactly `cfg_count` pixels. A `start` with a count of zero is ignored. With no frame running, `pix_ready` and `wr_valid` stay low.
- R10: `frame_done` is high for exactly one cycle, the cycle after the final word is accepted. `busy` is low in that cycle.
- R11: `pix_ready` is low while later words of an already taken pixel are still pending. A pixel is only taken together with an accepted word. A word held by a low `wr_ready` keeps its value.
- R12: During a frame, `start` pulses and configuration changes have no effect on the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dtype | input | 2 | Pixel type code |
| cfg_bus | input | 2 | Bus line count code |
| cfg_count | input | CNT_W | Pixels in the update |
| start | input | 1 | Begin an update (enable bit write) |
| cfg_bad | output | 1 | Current pairing has no cycle format |
| busy | output | 1 | Update running |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel taken this cycle if valid |
| pix_data | input | PIX_W | Pixel, right aligned |
| wr_valid | output | 1 | Bus write word offered |
| wr_ready | input | 1 | Bus cycle generator accepts the word |
| wr_data | output | BUS_W | Bus write word, right aligned |
| frame_done | output | 1 | One-cycle completion pulse |

## Verification
The word path is combinational from the pixel port and the phase state. So `wr_valid`, `wr_data` and `pix_ready` are due in the same cycle as the inputs that feed them. The bench drives on the falling edge and samples one nanosecond later, before the rising edge that commits the transfer. `busy` follows `start` by one rising edge. `frame_done` follows the final accepted word by one rising edge. The bench expects each of them at the first sample after that edge. Expected words come from concatenating the masked pixels of a group and slicing the result from the top. This is a different formulation from the design's phase-selected shifts.

// File: rtl/pix_bus_serializer.sv
module pix_bus_serializer #(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_dtype,
  input  logic [1:0]       cfg_bus,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             start,
  output logic             cfg_bad,
  output logic             busy,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [BUS_W-1:0] wr_data,
  output logic             frame_done
);

  localparam logic [1:0] FMT_ONE = 2'd0, FMT_TWO = 2'd1, FMT_THREE = 2'd2, FMT_PAIR = 2'd3;

  function automatic logic [4:0] lines_of(input logic [1:0] code);
    case (code)
      2'd0: lines_of = 5'd8;
      2'd1: lines_of = 5'd9;
      2'd2: lines_of = 5'd12;
      default: lines_of = 5'd16;
    endcase
  endfunction

  function automatic logic [4:0] bits_of(input logic [1:0] code);
    case (code)
      2'd0: bits_of = 5'd12;
      2'd1: bits_of = 5'd16;
      2'd2: bits_of = 5'd18;
      default: bits_of = 5'd24;
    endcase
  endfunction

  logic [1:0] fmt_c;
  logic       ok_c;

  always_comb begin
    ok_c  = 1'b1;
    fmt_c = FMT_ONE;
    case ({cfg_dtype, cfg_bus})
      4'b00_00: fmt_c = FMT_PAIR;
      4'b00_10: fmt_c = FMT_ONE;
      4'b01_00: fmt_c = FMT_TWO;
      4'b01_11: fmt_c = FMT_ONE;
      4'b10_01: fmt_c = FMT_TWO;
      4'b10_10: fmt_c = FMT_PAIR;
      4'b11_00: fmt_c = FMT_THREE;
      4'b11_10: fmt_c = FMT_TWO;
      4'b11_11: fmt_c = FMT_PAIR;
      default:  ok_c  = 1'b0;
    endcase
  end

  assign cfg_bad = !ok_c;

  logic [1:0]       dt_q, bus_q, fmt_q, ph;
  logic [CNT_W-1:0] rem;
  logic [PIX_W-1:0] cur;

  logic [4:0]       lw, hw, bw;
  logic [PIX_W-1:0] pmask, live, word;
  logic [BUS_W-1:0] wmask;
  logic [1:0]       last_ph;
  logic             lone, need_pix, fire, pix_take, grp_end, done_c;
  logic [CNT_W-1:0] rem_n;

  assign lw    = lines_of(bus_q);
  assign hw    = lw >> 1;
  assign bw    = bits_of(dt_q);
  assign pmask = ~({PIX_W{1'b1}} << bw);
  assign wmask = ~({BUS_W{1'b1}} << lw);
  assign live  = pix_data & pmask;

  assign last_ph  = (fmt_q == FMT_ONE) ? 2'd0 : (fmt_q == FMT_TWO) ? 2'd1 : 2'd2;
  assign lone     = busy && fmt_q == FMT_PAIR && ph == 2'd1 && rem == '0;
  assign need_pix = busy && (ph == 2'd0 || (fmt_q == FMT_PAIR && ph == 2'd1 && rem != '0));

  assign wr_valid  = busy && (!need_pix || pix_valid);
  assign pix_ready = need_pix && wr_ready;
  assign fire      = wr_valid && wr_ready;
  assign pix_take  = pix_valid && pix_ready;
  assign grp_end   = (ph == last_ph) || lone;
  assign rem_n     = rem - CNT_W'(pix_take);
  assign done_c    = fire && grp_end && rem_n == '0;

  always_comb begin
    word = '0;
    case (fmt_q)
      FMT_ONE:   word = live;
      FMT_TWO:   word = (ph == 2'd0) ? (live >> lw) : cur;
      FMT_THREE: begin
        if (ph == 2'd0)      word = live >> (lw << 1);
        else if (ph == 2'd1) word = cur >> lw;
        else                 word = cur;
      end
      default: begin
        if (ph == 2'd0)      word = live >> hw;
        else if (ph == 2'd1) word = (cur << hw) | (lone ? '0 : (live >> lw));
        else                 word = cur;
      end
    endcase
  end

  assign wr_data = word[BUS_W-1:0] & wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rem        <= '0;
      ph         <= 2'd0;
      cur        <= '0;
      dt_q       <= 2'd0;
      bus_q      <= 2'd0;
      fmt_q      <= FMT_ONE;
      frame_done <= 1'b0;
    end else begin
      frame_done <= done_c;
      if (!busy) begin
        if (start && ok_c && cfg_count != '0) begin
          busy  <= 1'b1;
          rem   <= cfg_count;
          ph    <= 2'd0;
          dt_q  <= cfg_dtype;
          bus_q <= cfg_bus;
          fmt_q <= fmt_c;
        end
      end else if (fire) begin
        if (pix_take) cur <= live;
        rem <= rem_n;
        ph  <= grp_end ? 2'd0 : ph + 2'd1;
        if (done_c) busy <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !pix_ready)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy); // R10
  AST_TAKE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |-> (wr_valid && wr_ready)); // R11
  AST_HELD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !need_pix && wr_valid && !wr_ready) |=> $stable(wr_data)); // R11
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_bad) |=> !busy); // R2

endmodule

// File: tb/pix_bus_serializer_tb.sv
module pix_bus_serializer_tb;
  localparam int PIX_W = 24, BUS_W = 16, CNT_W = 24;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_dtype = 0, cfg_bus = 0;
  logic [CNT_W-1:0] cfg_count = 0;
  logic start = 0, pix_valid = 0, wr_ready = 0;
  logic [PIX_W-1:0] pix_data = 0;
  logic cfg_bad, busy, pix_ready, wr_valid, frame_done;
  logic [BUS_W-1:0] wr_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [BUS_W-1:0] exp_q[$];
  logic [PIX_W-1:0] pix[0:63];

  always #10 clk = ~clk;

  pix_bus_serializer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dtype(cfg_dtype), .cfg_bus(cfg_bus),
    .cfg_count(cfg_count), .start(start), .cfg_bad(cfg_bad), .busy(busy),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .frame_done(frame_done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int lines_t(input logic [1:0] c);
    return (c == 0) ? 8 : (c == 1) ? 9 : (c == 2) ? 12 : 16;
  endfunction
  function automatic int bits_t(input logic [1:0] c);
    return (c == 0) ? 12 : (c == 1) ? 16 : (c == 2) ? 18 : 24;
  endfunction
  function automatic int fmt_t(input logic [1:0] dt, input logic [1:0] bs);
    int b = bits_t(dt), l = lines_t(bs);
    if (b % l == 0 && b / l >= 1 && b / l <= 3) return b / l - 1;
    if ((2 * b) % l == 0 && (2 * b) / l == 3) return 3;
    return -1;
  endfunction

  task automatic build(input logic [1:0] dt, input logic [1:0] bs, input int cnt);
    int l = lines_t(bs), b = bits_t(dt), f = fmt_t(dt, bs);
    longint lm = (64'd1 << l) - 1, bm = (64'd1 << b) - 1;
    exp_q.delete();
    if (f < 3) begin
      for (int i = 0; i < cnt; i++)
        for (int k = f; k >= 0; k--)
          exp_q.push_back(BUS_W'((longint'(pix[i]) & bm) >> (k * l) & lm));
    end else begin
      for (int i = 0; i < cnt; i += 2) begin
        longint a = longint'(pix[i]) & bm;
        longint c = (i + 1 < cnt) ? (longint'(pix[i+1]) & bm) : 0;
        longint v = (a << (3 * l / 2)) | c;
        exp_q.push_back(BUS_W'((v >> (2 * l)) & lm));
        exp_q.push_back(BUS_W'((v >> l) & lm));
        if (i + 1 < cnt) exp_q.push_back(BUS_W'(v & lm));
      end
    end
  endtask

  task automatic run_frame(input logic [1:0] dt, input logic [1:0] bs, input int cnt,
                           input bit stall, input bit poke, input int seed, input string req);
    int f = fmt_t(dt, bs), n = (fmt_t(dt, bs) == 0) ? 1 : (fmt_t(dt, bs) == 1) ? 2 : 3;
    int wi = 0, pi = 0, viol = 0, it = 0, last_fire_it = -5, done_it = -1, done_cnt = 0;
    bit done_busy = 0;
    for (int i = 0; i < 64; i++)
      pix[i] = PIX_W'(i * 32'h9E3779B1 + seed * 32'h01234567 + 32'hFF0000);
    build(dt, bs, cnt);
    @(negedge clk);
    cfg_dtype = dt; cfg_bus = bs; cfg_count = CNT_W'(cnt); start = 1;
    while (it < 2000) begin
      @(negedge clk);
      start = 0;
      if (poke && it == 2) begin
        start = 1; cfg_dtype = 2'd2; cfg_bus = 2'd1; cfg_count = 24'd1;
      end
      pix_valid = (pi < cnt) && !(stall && (it % 4 == 2));
      pix_data  = pix[pi < 64 ? pi : 0];
      wr_ready  = !(stall && (it % 3 == 1));
      #1;
      if (frame_done) begin
        done_cnt++;
        if (done_it < 0) begin done_it = it; done_busy = busy; end
      end
      if (done_it >= 0 && it > done_it) break;
      if (pix_ready) begin
        int p = wi % n;
        bit lone = (f == 3) && (pi == cnt);
        if (!(p == 0 || (f == 3 && p == 1 && !lone))) viol++;
      end
      if (wr_valid && wr_ready) begin
        logic [BUS_W-1:0] e = (wi < exp_q.size()) ? exp_q[wi] : '0;
        chk(wr_data === e, req, wr_data, e);
        wi++;
        last_fire_it = it;
      end
      if (pix_valid && pix_ready) pi++;
      it++;
    end
    chk(wi == exp_q.size(), "R9 word count", wi, exp_q.size());
    chk(pi == cnt, "R9 pixels consumed", pi, cnt);
    chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    chk(done_it == last_fire_it + 1, "R10 done timing", done_it, last_fire_it + 1);
    chk(!done_busy, "R10 busy clear with done", done_busy, 0);
    chk(viol == 0, "R11 ready during pending words", viol, 0);
    #1;
    chk(!pix_ready && !wr_valid, "R9 idle after frame", {pix_ready, wr_valid}, 0);
    pix_valid = 0; wr_ready = 0; start = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !wr_valid && !pix_ready && !frame_done, "R1 reset state",
        {busy, wr_valid, pix_ready, frame_done}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!busy && !wr_valid && !frame_done, "R1 after release", {busy, wr_valid, frame_done}, 0);
  endtask

  task automatic t_reject;
    @(negedge clk);
    cfg_dtype = 2'd0; cfg_bus = 2'd1; cfg_count = 24'd4; start = 1; pix_valid = 1; wr_ready = 1;
    #1;
    chk(cfg_bad, "R2 12-bit on 9 lines rejected", cfg_bad, 1);
    @(negedge clk); start = 0;
    #1;
    chk(!busy && !wr_valid, "R2 start ignored", {busy, wr_valid}, 0);
    cfg_dtype = 2'd1; cfg_bus = 2'd2;
    #1;
    chk(cfg_bad, "R2 16-bit on 12 lines rejected", cfg_bad, 1);
    cfg_dtype = 2'd2; cfg_bus = 2'd2;
    #1;
    chk(!cfg_bad, "R2 18-bit on 12 lines accepted", cfg_bad, 0);
    pix_valid = 0; wr_ready = 0;
  endtask

  task automatic t_zero_count;
    @(negedge clk);
    cfg_dtype = 2'd3; cfg_bus = 2'd0; cfg_count = 0; start = 1;
    @(negedge clk); start = 0;
    #1;
    chk(!busy && !pix_ready, "R9 zero count ignored", {busy, pix_ready}, 0);
  endtask

  initial begin
    t_reset();
    t_reject();
    run_frame(2'd1, 2'd3, 5, 0, 0, 1, "R3 16/16 word");
    run_frame(2'd0, 2'd2, 3, 1, 0, 2, "R8 12/12 word masked");
    run_frame(2'd1, 2'd0, 4, 1, 0, 3, "R4 16/8 word");
    run_frame(2'd2, 2'd1, 3, 0, 0, 4, "R4 18/9 word");
    run_frame(2'd3, 2'd2, 3, 1, 0, 5, "R4 24/12 word");
    run_frame(2'd3, 2'd0, 4, 1, 0, 6, "R5 24/8 word");
    run_frame(2'd0, 2'd0, 4, 0, 0, 7, "R6 12/8 word");
    run_frame(2'd3, 2'd3, 6, 1, 0, 8, "R6 24/16 word");
    run_frame(2'd2, 2'd2, 2, 0, 0, 9, "R6 18/12 word");
    run_frame(2'd3, 2'd3, 3, 1, 0, 10, "R7 odd count word");
    run_frame(2'd0, 2'd0, 1, 0, 0, 11, "R7 single lone word");
    run_frame(2'd3, 2'd0, 5, 0, 1, 12, "R12 word under restart");
    t_zero_count();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule